// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor

This block merges the health of up to four supply rails into one active-low system reset. For every rail it takes three flags: the threshold comparator result, the rail enable, and the rail's own power-good output. It also takes an active-low manual-reset request and an undervoltage-lockout flag. Any rail that is low, disabled or not yet reporting good pulls the reset low on the next clock edge. A manual-reset request does the same once it passes a glitch filter, and so does the lockout flag.

The reset is released only after every release condition has held without a break for a whole timeout. The timeout is either a fixed default of 190 ms worth of clock cycles, which sits inside a 140 ms to 260 ms window, or a cycle count supplied at a configuration input. Any fault that appears during the timeout clears the count, and a new full timeout starts once the conditions are clean again. A parameter sets how many rail lanes are in use. Lanes above that count are treated as always good and do not block release.

Top module: `rail_reset_supervisor`

## Requirements
- R1: For any lane with index below NUM_RAILS, a low `rail_ok`, `rail_en` or `rail_pgood` bit drives `sys_rst_n` low at the first clock edge that samples it.
- R2: `sys_rst_n` rises only after the release conditions hold on `limit` consecutive clock edges. The conditions are: every active lane is good, enabled and reporting power-good; manual reset is released; lockout is clear. `sys_rst_n` is high after exactly the `limit`-th such edge.
- R3: With `tmo_sel`=0, `limit` is CLK_HZ*190/1000 cycles (190 cycles at CLK_HZ=1000). With `tmo_sel`=1, `limit` equals `tmo_cycles`, and a value of 0 counts as 1.
- R4: A fault at any point during the timeout restarts it, so a full `limit` of clean edges is needed again. The timeout counter stays cleared while reset is released.
- R5: `mr_n` goes through a two-flop synchronizer. A low pulse shorter than MR_FILT_CYC synchronized samples never asserts reset. A pulse of at least MR_FILT_CYC samples asserts it. After `mr_n` returns high, release comes `limit`+3 edges later.
- R6: `uvlo`=1 drives `sys_rst_n` low at the next edge and keeps it low for as long as `uvlo` is high, whatever the rail inputs are.
- R7: Lanes with index NUM_RAILS and above are ignored: their input bits have no effect on `sys_rst_n`.
- R8: Synchronous active-high `rst` holds `sys_rst_n` low and clears the counter and the filter. With clean inputs, release comes `limit` edges after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | 4 | Per-lane comparator result, 1 = above threshold |
| rail_en | input | 4 | Per-lane enable, 1 = enabled |
| rail_pgood | input | 4 | Per-lane power-good output state, 1 = high |
| mr_n | input | 1 | Asynchronous active-low manual-reset request |
| uvlo | input | 1 | Undervoltage lockout, 1 = forces reset |
| tmo_sel | input | 1 | 0 = fixed default timeout, 1 = configured timeout |
| tmo_cycles | input | TMO_W | Configured timeout in clock cycles |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench runs a configuration with three active lanes, a 4-sample manual-reset filter and a 1 kHz nominal clock, so the default timeout is short. It first sweeps all 512 combinations of the nine active rail bits from the released state, with the unused fourth lane held bad. This shows that every single bit can assert reset, that only the all-good pattern keeps it released, and that the unused lane is ignored. Configured timeouts from 0 to 20 and the default are then measured edge by edge from the last fault, to confirm the exact release count. Fault bursts in the middle of a count, lockout, held manual resets and manual-reset pulses of 1 to 7 cycles follow. These separate a restart from a pause in the count, and a filtered glitch from a real request.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    localparam int MAX_RAILS = 4;
    localparam int DEF_TIMEOUT_MS = 190;

    // One lane's three release conditions.
    typedef struct packed {
        logic above;
        logic enabled;
        logic pgood;
    } lane_stat_t;

    typedef enum logic {
        SUP_HOLD    = 1'b0,
        SUP_RELEASE = 1'b1
    } sup_state_t;

    // Default timeout in cycles (typical point of the 140..260 ms window).
    function automatic longint default_cycles(input longint clk_hz);
        longint c;
        c = (clk_hz * DEF_TIMEOUT_MS) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic logic lane_good(input lane_stat_t s);
        return s.above & s.enabled & s.pgood;
    endfunction

endpackage

// File: rtl/rsup_lane_merge.sv
module rsup_lane_merge
    import rsup_pkg::*;
#(
    parameter int NUM_RAILS = 4
) (
    input  logic [MAX_RAILS-1:0] rail_ok,
    input  logic [MAX_RAILS-1:0] rail_en,
    input  logic [MAX_RAILS-1:0] rail_pgood,
    output logic                 all_good
);

    logic [MAX_RAILS-1:0] lane_ok;

    for (genvar i = 0; i < MAX_RAILS; i++) begin : g_lane
        if (i < NUM_RAILS) begin : g_used
            lane_stat_t st;
            assign st.above   = rail_ok[i];
            assign st.enabled = rail_en[i];
            assign st.pgood   = rail_pgood[i];
            assign lane_ok[i] = lane_good(st);
        end else begin : g_unused
            // R7: unused lane always counts as good
            assign lane_ok[i] = 1'b1;
        end
    end

    assign all_good = &lane_ok;

endmodule

// File: rtl/rsup_mr_filter.sv
module rsup_mr_filter #(
    parameter int MR_FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n,
    output logic mr_active
);

    localparam int FW = $clog2(MR_FILT_CYC + 1);
    localparam logic [FW-1:0] FILT_MAX = FW'(MR_FILT_CYC);

    logic          sync1, sync2;
    logic [FW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= mr_n;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!sync2) begin
            if (low_cnt != FILT_MAX) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign mr_active = (low_cnt == FILT_MAX);

    AST_MR_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(mr_active) |-> $past(!sync2)); // R5

    AST_MR_DROPS_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sync2 && mr_active) |=> !mr_active); // R5

endmodule

// File: rtl/rsup_timeout.sv
module rsup_timeout
    import rsup_pkg::*;
#(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault,
    input  logic [TMO_W-1:0] limit,
    output logic             released
);

    sup_state_t       state;
    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] cnt_nx;

    assign cnt_nx = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SUP_HOLD;
            cnt   <= '0;
        end else if (fault) begin
            state <= SUP_HOLD;
            cnt   <= '0;
        end else if (state == SUP_HOLD) begin
            if (cnt_nx >= limit) begin
                state <= SUP_RELEASE;
                cnt   <= '0;
            end else begin
                cnt   <= cnt_nx;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign released = (state == SUP_RELEASE);

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        fault |=> !released); // R1

    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(released) |-> $past(!fault)); // R2

    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        released |-> (cnt == '0)); // R4

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (!released && $stable(limit)) |-> (cnt < limit)); // R2

endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
    import rsup_pkg::*;
#(
    parameter int NUM_RAILS   = 4,
    parameter int CLK_HZ      = 50_000_000,
    parameter int MR_FILT_CYC = (CLK_HZ / 1_000_000) * 2 + 1,
    parameter int TMO_W       = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MAX_RAILS-1:0] rail_ok,
    input  logic [MAX_RAILS-1:0] rail_en,
    input  logic [MAX_RAILS-1:0] rail_pgood,
    input  logic                 mr_n,
    input  logic                 uvlo,
    input  logic                 tmo_sel,
    input  logic [TMO_W-1:0]     tmo_cycles,
    output logic                 sys_rst_n
);

    localparam longint DEF_CYC = default_cycles(longint'(CLK_HZ));
    localparam logic [TMO_W-1:0] DEF_LIMIT = TMO_W'(DEF_CYC);

    logic             rails_good;
    logic             mr_active;
    logic             fault;
    logic [TMO_W-1:0] limit;

    rsup_lane_merge #(.NUM_RAILS(NUM_RAILS)) u_merge (
        .rail_ok    (rail_ok),
        .rail_en    (rail_en),
        .rail_pgood (rail_pgood),
        .all_good   (rails_good)
    );

    rsup_mr_filter #(.MR_FILT_CYC(MR_FILT_CYC)) u_mrf (
        .clk       (clk),
        .rst       (rst),
        .mr_n      (mr_n),
        .mr_active (mr_active)
    );

    always_comb begin
        if (!tmo_sel)                limit = DEF_LIMIT;
        else if (tmo_cycles == '0)   limit = TMO_W'(1);
        else                         limit = tmo_cycles;
    end

    assign fault = uvlo | mr_active | !rails_good;

    rsup_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .fault    (fault),
        .limit    (limit),
        .released (sys_rst_n)
    );

    AST_UVLO_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> !sys_rst_n); // R6

    AST_RAIL_FAULT_LOW: assert property (@(posedge clk) disable iff (rst)
        !rails_good |=> !sys_rst_n); // R1

    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !sys_rst_n); // R8

endmodule

// File: tb/rail_reset_supervisor_tb.sv
module rail_reset_supervisor_tb;

    localparam int NR = 3;
    localparam int FILT = 4;
    localparam int TW = 16;
    localparam int DEF_EXP = 190; // 1000 Hz * 190 ms

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    rail_ok, rail_en, rail_pgood;
    logic          mr_n, uvlo, tmo_sel;
    logic [TW-1:0] tmo_cycles;
    logic          sys_rst_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    rail_reset_supervisor #(
        .NUM_RAILS(NR), .CLK_HZ(1000), .MR_FILT_CYC(FILT), .TMO_W(TW)
    ) u_dut (
        .clk(clk), .rst(rst), .rail_ok(rail_ok), .rail_en(rail_en),
        .rail_pgood(rail_pgood), .mr_n(mr_n), .uvlo(uvlo),
        .tmo_sel(tmo_sel), .tmo_cycles(tmo_cycles), .sys_rst_n(sys_rst_n)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_clean();
        rail_ok = 4'hF; rail_en = 4'hF; rail_pgood = 4'hF;
        mr_n = 1'b1; uvlo = 1'b0;
    endtask

    // Edges from now until sys_rst_n is first seen high.
    task automatic measure(output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while (!sys_rst_n && k < 400);
    endtask

    task automatic to_released();
        int k;
        set_clean();
        measure(k);
    endtask

    task automatic force_hold();
        uvlo = 1'b1;
        tick();
        tick();
    endtask

    initial begin
        int k;
        rst = 1'b1;
        set_clean();
        tmo_sel = 1'b1;
        tmo_cycles = TW'(3);
        tick(); tick(); tick();
        chk("R8 reset holds low", sys_rst_n, 0);
        rst = 1'b0;
        measure(k);
        chk("R8 first release count", k, 3);

        // R1/R7: exhaustive sweep of the 9 active lane bits, unused lane bad
        for (int c = 0; c < 512; c++) begin
            to_released();
            for (int i = 0; i < 3; i++) begin
                rail_ok[i]    = c[i];
                rail_en[i]    = c[3+i];
                rail_pgood[i] = c[6+i];
            end
            rail_ok[3] = 1'b0; rail_en[3] = 1'b0; rail_pgood[3] = 1'b0;
            tick();
            chk((c == 511) ? "R7 unused lane ignored" : "R1 lane fault asserts",
                sys_rst_n, (c == 511) ? 1 : 0);
        end

        // R2/R3: configured timeouts 0..20
        for (int t = 0; t <= 20; t++) begin
            tmo_cycles = TW'(t);
            force_hold();
            set_clean();
            measure(k);
            chk("R3 configured timeout", k, (t == 0) ? 1 : t);
        end

        // R3: default timeout
        tmo_sel = 1'b0;
        force_hold();
        set_clean();
        measure(k);
        chk("R3 default timeout", k, DEF_EXP);
        tmo_sel = 1'b1;

        // R4: fault in mid-count restarts a full timeout
        tmo_cycles = TW'(10);
        force_hold();
        set_clean();
        repeat (6) tick();
        chk("R4 still counting", sys_rst_n, 0);
        rail_en[1] = 1'b0;
        tick();
        set_clean();
        measure(k);
        chk("R4 restart full timeout", k, 10);
        chk("R2 released after count", sys_rst_n, 1);

        // R6: lockout forces low while held
        tmo_cycles = TW'(3);
        to_released();
        uvlo = 1'b1;
        tick();
        chk("R6 uvlo asserts", sys_rst_n, 0);
        repeat (20) tick();
        chk("R6 uvlo holds low", sys_rst_n, 0);
        set_clean();
        measure(k);
        chk("R6 release after uvlo", k, 3);

        // R5: held manual reset, release latency limit+3
        to_released();
        mr_n = 1'b0;
        repeat (10) tick();
        chk("R5 manual reset asserts", sys_rst_n, 0);
        mr_n = 1'b1;
        measure(k);
        chk("R5 manual release latency", k, 6);

        // R5: glitch filter, pulses of 1..7 cycles
        for (int len = 1; len <= 7; len++) begin
            int seen;
            to_released();
            seen = 0;
            mr_n = 1'b0;
            repeat (len) begin
                tick();
                if (!sys_rst_n) seen = 1;
            end
            mr_n = 1'b1;
            repeat (12) begin
                tick();
                if (!sys_rst_n) seen = 1;
            end
            chk("R5 glitch filter", seen, (len >= FILT) ? 1 : 0);
        end

        // R7: unused lane alone low
        to_released();
        rail_ok[3] = 1'b0;
        repeat (3) tick();
        chk("R7 lane 3 no effect", sys_rst_n, 1);

        finish_run();
    end

endmodule